// File: doc/BRIEF.md
# Nibble ALU Execute Stage with Conditional Skip

This block is the execute stage of a controller that fetches 16-bit instruction words and works on 4-bit data. For each executed word it decodes the arithmetic and compare classes, and takes two operands. These are either a general register against a data-memory nibble, or a data-memory nibble against a 4-bit immediate held in the word. From them it forms the result, the write-back target and a skip request. The skip request tells the sequencer to treat the next fetched word as a no-op.

The stage owns the shared carry/borrow flag. Add instructions leave the carry-out in it, and subtract instructions leave the borrow in it. The with-carry forms feed the flag back in as carry-in or borrow-in. Every arithmetic operation also has a form that skips when the new flag is set. Compares never write a result and never touch the flag: their only effect is the skip. Every instruction completes in one cycle. The result, the write strobe, the target fields and the skip are combinational in the execute cycle. The flag takes its new value at the closing clock edge.

Top module: `nib_alu_exec`

## Requirements
- R1: While reset is low, and after it rises, the flag output `carry_o` reads 0, whatever value the flag held before reset.
- R2: Opcode (bits 15:10) 010000 adds the register to the memory nibble. It drives the 4-bit sum on `result_o` with `wr_en_o`=1 and `wr_to_mem_o`=0, and register index = bits 3:0.
- R3: Opcode 010100 adds the immediate (bits 3:0) to the memory nibble. It drives the sum with `wr_en_o`=1 and `wr_to_mem_o`=1, and memory address `mem_addr_o` = {row bits 9:8, column bits 7:4}.
- R4: Opcode bit 11 set in the add group (bits 15:13 = 010) adds the current flag as carry-in. After the edge, the flag equals the carry out of bit 3.
- R5: Bits 15:13 = 011 subtract. With bit 12 clear the operation is register minus memory, written to the register. With bit 12 set it is memory minus immediate, written to memory. Bit 11 set also subtracts the current flag as borrow-in. The result is the difference modulo 16, and the flag becomes 1 exactly when the true difference is negative.
- R6: In the arithmetic group (bits 15:14 = 01), bit 10 set asserts `skip_o` exactly when the new flag is 1. Bit 10 clear never asserts `skip_o`.
- R7: The flag takes the new carry/borrow at the clock edge that closes every executed arithmetic instruction, whether or not it skips. Compares leave it unchanged.
- R8: The compares write nothing and assert `skip_o` on these conditions: 000100 when register = memory, 000101 when memory = immediate, 000001 when memory ≠ immediate, 000011 when register ≥ memory, 000111 when memory ≥ immediate (unsigned).
- R9: With `exec_en_i` low, `wr_en_o` and `skip_o` stay 0 and the flag keeps its value.
- R10: Any other opcode executes as a no-op: no write, no skip, flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_en_i | input | 1 | The word on instr_i executes this cycle |
| instr_i | input | 16 | Instruction word |
| reg_val_i | input | 4 | Value of the register selected by bits 3:0 |
| mem_val_i | input | 4 | Value of the memory nibble at {row, column} |
| result_o | output | 4 | Arithmetic result to write back |
| wr_en_o | output | 1 | Write-back strobe |
| wr_to_mem_o | output | 1 | Target select: 1 memory, 0 register |
| reg_idx_o | output | 4 | Register index for write-back |
| mem_addr_o | output | 6 | Memory address {row, column} for write-back |
| carry_o | output | 1 | Current carry/borrow flag |
| skip_o | output | 1 | Discard the next fetched instruction |

## Verification
Some properties are checked on every cycle. A compare never writes, an idle or non-arithmetic cycle leaves the flag alone, and plain arithmetic forms never skip. The flag left behind by a skipping arithmetic form also matches the skip it raised, and the ripple chain is compared against integer arithmetic. The exact results, the borrow-in and carry-in chaining across successive instructions, the ≥ boundary at equality, and the clearing of a set flag by reset are only shown by the bench. Its scenarios compute each result independently and follow the flag from one instruction to the next.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [1:0] {
    CMP_NONE = 2'd0,
    CMP_EQ   = 2'd1,
    CMP_NE   = 2'd2,
    CMP_GE   = 2'd3
  } cmp_kind_e;

  typedef struct packed {
    logic      arith;    // add/subtract group
    logic      sub;      // subtract instead of add
    logic      imm;      // memory vs immediate operand form
    logic      use_c;    // flag feeds carry/borrow in
    logic      skip_var; // skip on new flag
    cmp_kind_e cmp;      // compare kind, CMP_NONE if not a compare
  } dec_t;

  localparam logic [OPC_W-1:0] OPC_EQ_RM = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_EQ_MI = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_NE_MI = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_GE_RM = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_GE_MI = 6'b000111;

endpackage

// File: rtl/nib_alu_decode.sv
module nib_alu_decode
  import nib_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);

  always_comb begin
    dec_o          = '0;
    dec_o.cmp      = CMP_NONE;
    if (opc_i[5:4] == 2'b01) begin
      dec_o.arith    = 1'b1;
      dec_o.sub      = opc_i[3];
      dec_o.imm      = opc_i[2];
      dec_o.use_c    = opc_i[1];
      dec_o.skip_var = opc_i[0];
    end else begin
      unique case (opc_i)
        OPC_EQ_RM: begin dec_o.cmp = CMP_EQ; dec_o.imm = 1'b0; end
        OPC_EQ_MI: begin dec_o.cmp = CMP_EQ; dec_o.imm = 1'b1; end
        OPC_NE_MI: begin dec_o.cmp = CMP_NE; dec_o.imm = 1'b1; end
        OPC_GE_RM: begin dec_o.cmp = CMP_GE; dec_o.imm = 1'b0; end
        OPC_GE_MI: begin dec_o.cmp = CMP_GE; dec_o.imm = 1'b1; end
        default:   dec_o.cmp = CMP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/nib_alu_addsub.sv
module nib_alu_addsub #(
  parameter int DATA_W = 4
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,   // carry-in for add, borrow-in for subtract
  output logic [DATA_W-1:0] sum_o,
  output logic              flag_o   // carry-out for add, borrow-out for subtract
);

  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W:0]   c;
  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign c[0]  = sub_i ? ~cin_i : cin_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
  end

  assign flag_o = sub_i ? ~c[DATA_W] : c[DATA_W];

  logic [EXT_W-1:0] a_ext, b_ext, ci_ext;
  assign a_ext  = {1'b0, a_i};
  assign b_ext  = {1'b0, b_i};
  assign ci_ext = EXT_W'(cin_i);

  always_comb begin
    if (!sub_i) begin
      p_add_chain_r4: assert ({flag_o, sum_o} == a_ext + b_ext + ci_ext)
        else $error("ripple add mismatch");
    end else begin
      p_sub_chain_r5: assert ((sum_o == DATA_W'(a_ext - b_ext - ci_ext)) &&
                              (flag_o == (a_ext < b_ext + ci_ext)))
        else $error("ripple subtract mismatch");
    end
  end

endmodule

// File: rtl/nib_alu_cmp.sv
module nib_alu_cmp
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  cmp_kind_e         kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              hit_o
);

  logic eq, ge;
  assign eq = (a_i == b_i);
  assign ge = (a_i >= b_i);

  always_comb begin
    unique case (kind_i)
      CMP_EQ:  hit_o = eq;
      CMP_NE:  hit_o = ~eq;
      CMP_GE:  hit_o = ge;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nib_alu_exec.sv
module nib_alu_exec
  import nib_alu_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int ROW_W   = 2,
  parameter int COL_W   = 4,
  parameter int INSTR_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     exec_en_i,
  input  logic [INSTR_W-1:0]       instr_i,
  input  logic [DATA_W-1:0]        reg_val_i,
  input  logic [DATA_W-1:0]        mem_val_i,
  output logic [DATA_W-1:0]        result_o,
  output logic                     wr_en_o,
  output logic                     wr_to_mem_o,
  output logic [DATA_W-1:0]        reg_idx_o,
  output logic [ROW_W+COL_W-1:0]   mem_addr_o,
  output logic                     carry_o,
  output logic                     skip_o
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int OPC_LO = INSTR_W - OPC_W;

  dec_t              dec;
  logic [DATA_W-1:0] imm, opnd_a, opnd_b, sum;
  logic              carry_q, cin, flag_new, cmp_hit;
  logic              arith_go, cmp_go;

  nib_alu_decode i_decode (
    .opc_i (instr_i[INSTR_W-1:OPC_LO]),
    .dec_o (dec)
  );

  assign imm        = instr_i[DATA_W-1:0];
  assign reg_idx_o  = instr_i[DATA_W-1:0];
  assign mem_addr_o = instr_i[DATA_W+ADDR_W-1:DATA_W];

  // memory moves to the left operand in the immediate forms
  assign opnd_a = dec.imm ? mem_val_i : reg_val_i;
  assign opnd_b = dec.imm ? imm       : mem_val_i;
  assign cin    = dec.use_c & carry_q;

  nib_alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .sub_i  (dec.sub),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .cin_i  (cin),
    .sum_o  (sum),
    .flag_o (flag_new)
  );

  nib_alu_cmp #(.DATA_W(DATA_W)) i_cmp (
    .kind_i (dec.cmp),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .hit_o  (cmp_hit)
  );

  assign arith_go    = exec_en_i & dec.arith;
  assign cmp_go      = exec_en_i & (dec.cmp != CMP_NONE);

  assign result_o    = sum;
  assign wr_en_o     = arith_go;
  assign wr_to_mem_o = dec.imm;
  assign skip_o      = (arith_go & dec.skip_var & flag_new) | (cmp_go & cmp_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_q <= 1'b0;
    else if (arith_go) carry_q <= flag_new;
  end

  assign carry_o = carry_q;

  p_cmp_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_go |-> !wr_en_o)
    else $error("compare raised a write");

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_en_i |-> (!wr_en_o && !skip_o))
    else $error("idle cycle wrote or skipped");

  p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |=> (carry_o == $past(carry_o)))
    else $error("flag changed without arithmetic");

  p_plain_noskip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !instr_i[OPC_LO]) |-> !skip_o)
    else $error("plain arithmetic form skipped");

  p_skip_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && instr_i[OPC_LO]) |=> (carry_o == $past(skip_o)))
    else $error("skip disagrees with stored flag");

endmodule

// File: tb/test_nib_alu_exec.sv
module test_nib_alu_exec;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        exec_en;
  logic [15:0] instr;
  logic [3:0]  reg_val, mem_val;
  logic [3:0]  result;
  logic        wr_en, wr_to_mem, carry, skip;
  logic [3:0]  reg_idx;
  logic [5:0]  mem_addr;

  int checks = 0;
  int errors = 0;
  logic model_flag = 1'b0;

  always #4 clk = ~clk;

  nib_alu_exec i_nib_alu_exec (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .exec_en_i   (exec_en),
    .instr_i     (instr),
    .reg_val_i   (reg_val),
    .mem_val_i   (mem_val),
    .result_o    (result),
    .wr_en_o     (wr_en),
    .wr_to_mem_o (wr_to_mem),
    .reg_idx_o   (reg_idx),
    .mem_addr_o  (mem_addr),
    .carry_o     (carry),
    .skip_o      (skip)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (instr=%h)", req, act, exp, instr);
    end
  endtask

  function automatic logic [15:0] mk(input logic [5:0] opc, input logic [5:0] addr,
                                     input logic [3:0] low);
    return {opc, addr, low};
  endfunction

  // reference model from the requirements
  task automatic model(input logic [15:0] ins, input logic [3:0] r, m, input logic en,
                       input logic fl, output int res, output bit we, output bit to_mem,
                       output bit sk, output bit nfl, output string tag);
    logic [5:0] op;
    int a, b, t, k;
    op = ins[15:10];
    res = 0; we = 0; to_mem = 0; sk = 0; nfl = fl; tag = "R10";
    if (!en) begin
      tag = "R9";
    end else if (op[5:4] == 2'b01) begin
      a = op[2] ? int'(m) : int'(r);
      b = op[2] ? int'(ins[3:0]) : int'(m);
      k = op[1] ? int'(fl) : 0;
      if (!op[3]) begin
        t = a + b + k;
        nfl = (t > 15);
        tag = op[1] ? "R4" : (op[2] ? "R3" : "R2");
      end else begin
        t = a - b - k;
        nfl = (t < 0);
        tag = "R5";
      end
      res = (t + 32) % 16;
      we = 1; to_mem = op[2];
      sk = op[0] && nfl;
    end else begin
      tag = "R8";
      case (op)
        6'b000100: sk = (r == m);
        6'b000101: sk = (m == ins[3:0]);
        6'b000001: sk = (m != ins[3:0]);
        6'b000011: sk = (r >= m);
        6'b000111: sk = (m >= ins[3:0]);
        default:   tag = "R10";
      endcase
    end
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [3:0] r, m, input logic en);
    int res; bit we, to_mem, sk, nfl; string tag, sktag;
    @(negedge clk);
    instr = ins; reg_val = r; mem_val = m; exec_en = en;
    #1;
    model(ins, r, m, en, model_flag, res, we, to_mem, sk, nfl, tag);
    chk(tag, int'(wr_en), int'(we));
    if (we) begin
      chk(tag, int'(result), res);
      chk(tag, int'(wr_to_mem), int'(to_mem));
      if (to_mem) chk("R3", int'(mem_addr), int'(ins[9:4]));
      else        chk("R2", int'(reg_idx), int'(ins[3:0]));
    end
    sktag = (tag == "R8" || tag == "R9" || tag == "R10") ? tag : "R6";
    chk(sktag, int'(skip), int'(sk));
    @(posedge clk); #1;
    model_flag = nfl;
    chk((we ? "R7" : (tag == "R8" ? "R7" : tag)), int'(carry), int'(model_flag));
  endtask

  initial begin
    rst_ni = 1'b0; exec_en = 1'b0; instr = '0; reg_val = '0; mem_val = '0;
    #1;
    chk("R1", int'(carry), 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(carry), 0);
    chk("R9", int'(wr_en), 0);
    @(negedge clk); rst_ni = 1'b1;

    // directed corners
    run_op(mk(6'b010000, 6'h2A, 4'h3), 4'hF, 4'h1, 1'b1); // R2 wrap, carry out
    run_op(mk(6'b010000, 6'h00, 4'h5), 4'h2, 4'h3, 1'b1); // R2 no carry
    run_op(mk(6'b010100, 6'h3F, 4'h7), 4'h0, 4'h9, 1'b1); // R3 9+7 carry
    run_op(mk(6'b010010, 6'h11, 4'h1), 4'h7, 4'h8, 1'b1); // R4 carry-in makes 16
    run_op(mk(6'b010110, 6'h05, 4'hE), 4'h0, 4'h0, 1'b1); // R4 imm with carry
    run_op(mk(6'b011000, 6'h09, 4'h2), 4'h3, 4'h5, 1'b1); // R5 borrow
    run_op(mk(6'b011010, 6'h09, 4'h2), 4'h5, 4'h5, 1'b1); // R5 borrow-in -> -1
    run_op(mk(6'b011110, 6'h21, 4'h0), 4'h0, 4'h0, 1'b1); // R5 imm borrow-in
    run_op(mk(6'b011101, 6'h21, 4'h4), 4'h0, 4'h4, 1'b1); // R6 SI skip not taken
    run_op(mk(6'b010001, 6'h00, 4'h1), 4'h8, 4'h8, 1'b1); // R6 skip taken
    run_op(mk(6'b000100, 6'h01, 4'h2), 4'h6, 4'h6, 1'b1); // R8 eq hit, flag held
    run_op(mk(6'b000101, 6'h01, 4'h6), 4'h0, 4'h5, 1'b1); // R8 eq miss
    run_op(mk(6'b000001, 6'h01, 4'h6), 4'h0, 4'h5, 1'b1); // R8 ne hit
    run_op(mk(6'b000011, 6'h01, 4'h0), 4'h7, 4'h7, 1'b1); // R8 ge at equality
    run_op(mk(6'b000111, 6'h01, 4'h8), 4'h0, 4'h7, 1'b1); // R8 ge miss
    run_op(mk(6'b111111, 6'h3F, 4'hF), 4'hF, 4'hF, 1'b1); // R10 unknown
    run_op(mk(6'b010001, 6'h00, 4'h1), 4'hF, 4'hF, 1'b0); // R9 disabled
    run_op(mk(6'b010000, 6'h00, 4'h1), 4'hF, 4'hF, 1'b1); // set flag

    // reset clears a set flag
    @(negedge clk); exec_en = 1'b0; rst_ni = 1'b0;
    #1; model_flag = 1'b0;
    chk("R1", int'(carry), 0);
    @(negedge clk); rst_ni = 1'b1;

    // constrained random
    void'($urandom(32'd2718));
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ins;
      int pick;
      ins = 16'($urandom);
      pick = $urandom_range(0, 24);
      if (pick < 16)       ins[15:10] = {2'b01, 4'(pick)};
      else if (pick == 16) ins[15:10] = 6'b000100;
      else if (pick == 17) ins[15:10] = 6'b000101;
      else if (pick == 18) ins[15:10] = 6'b000001;
      else if (pick == 19) ins[15:10] = 6'b000011;
      else if (pick == 20) ins[15:10] = 6'b000111;
      run_op(ins, 4'($urandom), 4'($urandom), ($urandom_range(0, 9) != 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule